// File: doc/BRIEF.md
# Monitor Status Descriptor Ring Producer

This block sits beside a DMA engine that streams 32-bit status words into a fixed-size status buffer. Each word is part of a variable-length record. A record is marked complete by a flag on its final word. The block counts the words as they land. When the buffer closes, it assembles a 128-bit completion descriptor and offers it as a write into a circular ring in memory, at the current producer slot.

A buffer closes for one of four reasons: a system-level truncation, a flush, the end of the current frame, or the buffer filling up. The descriptor records the reason, the word offset where the buffer ended, the buffer's 64-bit virtual address, a 32-bit frame identifier, an initiator flag and a fixed 8-bit ring tag. It also carries a 4-bit wrap count. The consumer compares that count to find fresh entries, so it never has to read the producer index.

The consumer supplies its tail index. When the ring has no free slot, the block holds the descriptor and flags the overflow instead of overwriting. Each accepted write is followed by a one-cycle interrupt pulse.

Top module: `stat_ring_producer`

## Requirements
- R1: `desc_data` carries the buffer address low word in [31:0], the address high word in [63:32], the frame identifier in [95:64] and a control word in [127:96]. The control word holds the end offset in its bits [11:0], zeros in [15:12], the close code in [17:16], the initiator flag in [18], zero in [19], the parameter `RING_TAG` in [27:20] and the wrap count in [31:28]. Address, identifier and initiator are those present in the close cycle.
- R2: On an end-of-frame or truncation close, the end offset is the word index of the most recent word written with `wr_rec_last`=1 in the current buffer. Words of an unfinished record are excluded. The offset is 0 if no such word exists. A write in the close cycle counts.
- R3: On a flush close, the end offset is the index of the last word written into the current buffer, including a write in the close cycle. It is 0 if nothing was written.
- R4: The write that makes the buffer hold `BUF_WORDS` words closes it with code 0 and end offset `BUF_WORDS`-1.
- R5: Close codes are truncation=3, flush=1, end of frame=2 and buffer full=0. When several happen in one cycle, the highest wins, in the order truncation, flush, end of frame, full.
- R6: Every close event restarts word counting at index 0 for the next buffer.
- R7: `desc_slot` is 0 after reset. It advances by one on each accepted write (`desc_vld` and `desc_rdy` high) and wraps from `DEPTH`-1 to 0.
- R8: The wrap count is 0 after reset. It increments, modulo 16, each time the slot wraps to 0. Each descriptor carries the count in force when it is written.
- R9: If the slot after `desc_slot` equals `tail_idx`, the ring is full. A pending descriptor is then held with `desc_vld` low and `overflow` high until space appears.
- R10: A close event that arrives while a descriptor is held and not accepted in that cycle produces no descriptor. The held descriptor is unchanged, but word counting still restarts.
- R11: `irq` is high for exactly one cycle, the cycle after each accepted write, and is low otherwise.
- R12: After reset, `desc_vld`, `irq` and `overflow` are low and `desc_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | 1 | One status word written this cycle |
| wr_rec_last | input | 1 | The word written is the final word of its record |
| buf_addr | input | 64 | Virtual address of the current status buffer |
| frame_id | input | 32 | Identifier of the frame being recorded |
| origin | input | 1 | Initiator flag copied into the descriptor |
| ev_flush | input | 1 | Flush close event |
| ev_eof | input | 1 | End-of-frame close event |
| ev_trunc | input | 1 | Truncation close event |
| tail_idx | input | IDX_W | Consumer tail slot |
| desc_rdy | input | 1 | Memory side accepts the descriptor write |
| desc_vld | output | 1 | Descriptor write request |
| desc_slot | output | IDX_W | Ring slot for the write |
| desc_data | output | 128 | Four descriptor words |
| overflow | output | 1 | Descriptor pending but ring full |
| irq | output | 1 | New-entry pulse |

## Verification
Word streams are built so that the last completed record ends before the last written word. This makes the end-of-frame and flush offsets differ, and a write in the close cycle shows whether that word is counted. Coincident events, including an end-of-frame on the write that fills the buffer, separate the priority order from the full-buffer path. A pinned tail index exercises the stall, and a second close during the stall shows that it is dropped. A run of more than 128 short buffers takes the wrap count through all 16 values and back to 0.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    CLOSE_FULL  = 2'd0,
    CLOSE_FLUSH = 2'd1,
    CLOSE_EOF   = 2'd2,
    CLOSE_TRUNC = 2'd3
  } close_e;

  localparam int OFF_W  = 12;
  localparam int WRAP_W = 4;

  typedef struct packed {
    logic [63:0]      addr;
    logic [31:0]      fid;
    logic [OFF_W-1:0] eoff;
    close_e           why;
    logic             origin;
  } held_t;

  function automatic logic [31:0] pack_ctrl(
    input logic [OFF_W-1:0]  eoff,
    input close_e            why,
    input logic              origin,
    input logic [7:0]        tag,
    input logic [WRAP_W-1:0] wraps
  );
    return {wraps, tag, 1'b0, origin, why, 4'b0000, eoff};
  endfunction

endpackage

// File: rtl/srp_word_track.sv
module srp_word_track #(
  parameter int BUF_WORDS = 16,
  parameter int OFF_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic             wr_rec_last,
  input  logic             restart,
  output logic             full_hit,
  output logic [OFF_W-1:0] rec_off,
  output logic [OFF_W-1:0] last_off
);
  localparam int CNT_W = $clog2(BUF_WORDS) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUF_WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0] rec_q, rec_d;
  logic             upd_en;

  always_comb begin
    rec_off = (wr_vld && wr_rec_last) ? OFF_W'(cnt_q) : rec_q;
    if (wr_vld)
      last_off = OFF_W'(cnt_q);
    else if (cnt_q == '0)
      last_off = '0;
    else
      last_off = OFF_W'(cnt_q - 1'b1);
    full_hit = wr_vld && (cnt_q == CNT_LAST);

    upd_en = restart | wr_vld;
    cnt_d  = cnt_q;
    rec_d  = rec_q;
    if (restart) begin
      cnt_d = '0;
      rec_d = '0;
    end else if (wr_vld) begin
      cnt_d = cnt_q + 1'b1;
      rec_d = rec_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rec_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      rec_q <= rec_d;
    end
  end

endmodule

// File: rtl/srp_close_sel.sv
module srp_close_sel
  import srp_pkg::*;
#(
  parameter int BUF_WORDS = 16
) (
  input  logic             ev_trunc,
  input  logic             ev_flush,
  input  logic             ev_eof,
  input  logic             full_hit,
  input  logic [OFF_W-1:0] rec_off,
  input  logic [OFF_W-1:0] last_off,
  output logic             close_any,
  output close_e           why,
  output logic [OFF_W-1:0] eoff
);
  localparam logic [OFF_W-1:0] FULL_OFF = OFF_W'(BUF_WORDS - 1);

  always_comb begin
    close_any = ev_trunc | ev_flush | ev_eof | full_hit;
    if (ev_trunc) begin
      why  = CLOSE_TRUNC;
      eoff = rec_off;
    end else if (ev_flush) begin
      why  = CLOSE_FLUSH;
      eoff = last_off;
    end else if (ev_eof) begin
      why  = CLOSE_EOF;
      eoff = rec_off;
    end else begin
      why  = CLOSE_FULL;
      eoff = FULL_OFF;
    end
  end

endmodule

// File: rtl/srp_ring_idx.sv
module srp_ring_idx #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int WRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [IDX_W-1:0]  tail,
  output logic [IDX_W-1:0]  slot,
  output logic [WRAP_W-1:0] wraps,
  output logic              ring_full
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0]  slot_q, slot_d, slot_nx;
  logic [WRAP_W-1:0] wrap_q, wrap_d;
  logic              at_end;

  assign at_end = (slot_q == LAST_SLOT);

  generate
    if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign slot_nx = slot_q + 1'b1;
    end else begin : g_any
      assign slot_nx = at_end ? '0 : slot_q + 1'b1;
    end
  endgenerate

  always_comb begin
    ring_full = (slot_nx == tail);
    slot_d    = adv ? slot_nx : slot_q;
    wrap_d    = (adv && at_end) ? wrap_q + 1'b1 : wrap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      wrap_q <= '0;
    end else if (adv) begin
      slot_q <= slot_d;
      wrap_q <= wrap_d;
    end
  end

  assign slot  = slot_q;
  assign wraps = wrap_q;

endmodule

// File: rtl/stat_ring_producer.sv
module stat_ring_producer
  import srp_pkg::*;
#(
  parameter int         DEPTH     = 8,
  parameter int         BUF_WORDS = 16,
  parameter logic [7:0] RING_TAG  = 8'h5A,
  parameter int         IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic             wr_rec_last,
  input  logic [63:0]      buf_addr,
  input  logic [31:0]      frame_id,
  input  logic             origin,
  input  logic             ev_flush,
  input  logic             ev_eof,
  input  logic             ev_trunc,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic             desc_rdy,
  output logic             desc_vld,
  output logic [IDX_W-1:0] desc_slot,
  output logic [127:0]     desc_data,
  output logic             overflow,
  output logic             irq
);

  logic             full_hit, close_any, ring_full, accept, capture;
  logic [OFF_W-1:0] rec_off, last_off, sel_eoff;
  close_e           sel_why;
  logic [WRAP_W-1:0] wraps;
  held_t            hold_q, hold_d;
  logic             hold_vld_q, hold_vld_d;
  logic             irq_q;

  srp_word_track #(.BUF_WORDS(BUF_WORDS), .OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_rec_last(wr_rec_last),
    .restart(close_any), .full_hit(full_hit), .rec_off(rec_off), .last_off(last_off)
  );

  srp_close_sel #(.BUF_WORDS(BUF_WORDS)) u_sel (
    .ev_trunc(ev_trunc), .ev_flush(ev_flush), .ev_eof(ev_eof), .full_hit(full_hit),
    .rec_off(rec_off), .last_off(last_off),
    .close_any(close_any), .why(sel_why), .eoff(sel_eoff)
  );

  srp_ring_idx #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WRAP_W(WRAP_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(accept), .tail(tail_idx),
    .slot(desc_slot), .wraps(wraps), .ring_full(ring_full)
  );

  always_comb begin
    desc_vld   = hold_vld_q && !ring_full;
    overflow   = hold_vld_q && ring_full;
    accept     = desc_vld && desc_rdy;
    capture    = close_any && (!hold_vld_q || accept);
    hold_d.addr   = buf_addr;
    hold_d.fid    = frame_id;
    hold_d.eoff   = sel_eoff;
    hold_d.why    = sel_why;
    hold_d.origin = origin;
    if (capture)
      hold_vld_d = 1'b1;
    else if (accept)
      hold_vld_d = 1'b0;
    else
      hold_vld_d = hold_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      irq_q      <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_d;
      irq_q      <= accept;
      if (capture)
        hold_q <= hold_d;
    end
  end

  assign desc_data = {pack_ctrl(hold_q.eoff, hold_q.why, hold_q.origin, RING_TAG, wraps),
                      hold_q.fid, hold_q.addr};
  assign irq = irq_q;

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_vld,
  input logic             desc_rdy,
  input logic [IDX_W-1:0] desc_slot,
  input logic [127:0]     desc_data,
  input logic             overflow,
  input logic             irq
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld |-> (desc_data[111:108] == 4'b0000 && desc_data[115] == 1'b0)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && !desc_rdy) |=> $stable(desc_data)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !desc_vld); // R9

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && desc_rdy) |=>
      (desc_slot == (($past(desc_slot) == LAST_SLOT) ? '0 : IDX_W'($past(desc_slot) + 1'b1)))); // R7

  AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_vld && desc_rdy) |=> $stable(desc_slot)); // R7

  AST_IRQ_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_vld && desc_rdy) |=> irq); // R11

  AST_IRQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_vld && desc_rdy) |=> !irq); // R11

endmodule

bind stat_ring_producer srp_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/stat_ring_producer_tb_top.sv
module stat_ring_producer_tb_top;
  localparam int         DEPTH = 8;
  localparam int         BUFW  = 16;
  localparam int         IDX_W = 3;
  localparam logic [7:0] TAG   = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_vld = 0, wr_rec_last = 0, origin = 0, ev_flush = 0, ev_eof = 0, ev_trunc = 0;
  logic [63:0] buf_addr = '0;
  logic [31:0] frame_id = '0;
  logic [IDX_W-1:0] tail_idx, tail_q = '0, forced = '0;
  logic pin_tail = 0, desc_rdy = 1;
  logic desc_vld, overflow, irq;
  logic [IDX_W-1:0] desc_slot;
  logic [127:0] desc_data;

  always #10 clk = ~clk;

  stat_ring_producer #(.DEPTH(DEPTH), .BUF_WORDS(BUFW), .RING_TAG(TAG)) dut_i (.*);

  typedef struct {
    logic [63:0] a; logic [31:0] f; logic [11:0] e; logic [1:0] w; logic o; string req;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0, n_ev = 0, m_cnt = 0, m_rec = 0;
  int m_slot = 0, m_wraps = 0;
  bit done = 0, acc_prev = 0;

  always @(posedge clk) tail_q <= IDX_W'(m_slot);
  assign tail_idx = pin_tail ? forced : tail_q;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  // monitor: compares each accepted write with the scoreboard
  initial begin
    logic [127:0] expd;
    exp_t e;
    @(posedge rst_n);
    forever begin
      settle();
      chk(irq == acc_prev, "R11 irq pulse", 128'(irq), 128'(acc_prev));
      acc_prev = desc_vld && desc_rdy;
      if (acc_prev) begin
        if (q.size() == 0) begin
          chk(0, "R10 unexpected descriptor", desc_data, '0);
        end else begin
          e = q.pop_front();
          expd = {4'(m_wraps), TAG, 1'b0, e.o, e.w, 4'b0000, e.e, e.f, e.a};
          chk(desc_data == expd, {e.req, " R1 R8 descriptor"}, desc_data, expd);
          chk(desc_slot == IDX_W'(m_slot), "R7 slot", 128'(desc_slot), 128'(m_slot));
        end
        if (m_slot == DEPTH - 1) begin
          m_slot = 0;
          m_wraps = (m_wraps + 1) % 16;
        end else m_slot++;
      end
    end
  end

  task automatic step(input bit wr, input bit last, input bit tr, input bit fl, input bit eo,
                      input bit keep, input string req);
    int lastw;
    bit full;
    exp_t e;
    @(negedge clk);
    n_ev++;
    buf_addr = {32'hC0DE_0000 | 32'(n_ev), 32'h0040_0000 + 32'(n_ev * 64)};
    frame_id = 32'h7000_0000 + 32'(n_ev * 3);
    origin = n_ev[0];
    wr_vld = wr; wr_rec_last = last; ev_trunc = tr; ev_flush = fl; ev_eof = eo;
    full = 0;
    if (wr) begin
      lastw = m_cnt;
      if (last) m_rec = m_cnt;
      m_cnt++;
      full = (m_cnt == BUFW);
    end else lastw = (m_cnt == 0) ? 0 : m_cnt - 1;
    if (tr || fl || eo || full) begin
      e.a = buf_addr; e.f = frame_id; e.o = origin; e.req = req;
      if (tr)      begin e.w = 2'd3; e.e = 12'(m_rec);    end
      else if (fl) begin e.w = 2'd1; e.e = 12'(lastw);    end
      else if (eo) begin e.w = 2'd2; e.e = 12'(m_rec);    end
      else         begin e.w = 2'd0; e.e = 12'(BUFW - 1); end
      if (keep) q.push_back(e);
      m_cnt = 0;
      m_rec = 0;
    end
    @(posedge clk); #1;
    wr_vld = 0; wr_rec_last = 0; ev_trunc = 0; ev_flush = 0; ev_eof = 0;
  endtask

  task automatic wr1(input bit last);
    step(1, last, 0, 0, 0, 1, "R4");
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 40; i++) begin
      settle();
      if (q.size() == 0) break;
    end
    repeat (2) settle();
    chk(q.size() == 0, req, 128'(q.size()), '0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    chk(desc_vld == 0, "R12 desc_vld", 128'(desc_vld), 0);
    chk(irq == 0, "R12 irq", 128'(irq), 0);
    chk(overflow == 0, "R12 overflow", 128'(overflow), 0);
    chk(desc_slot == 0, "R12 slot", 128'(desc_slot), 0);

    // R2: end of frame uses last completed record end
    wr1(0); wr1(1); wr1(0); wr1(0);
    step(0, 0, 0, 0, 1, 1, "R2 eof offset 1");
    drain("R2 drained");
    step(0, 0, 0, 0, 1, 1, "R2 eof empty buffer offset 0");
    drain("R2 drained empty");
    // R3: flush uses last written word
    wr1(0); wr1(0); wr1(1); wr1(0); wr1(0);
    step(0, 0, 0, 1, 0, 1, "R3 flush offset 4");
    drain("R3 drained");
    wr1(0);
    step(1, 0, 0, 1, 0, 1, "R3 flush with write in close cycle offset 1");
    drain("R3 drained same cycle");
    // R5: priorities
    wr1(0); wr1(0); wr1(1);
    step(0, 0, 1, 0, 0, 1, "R5 truncation offset 2");
    drain("R5 drained trunc");
    wr1(1);
    step(0, 0, 1, 1, 1, 1, "R5 trunc beats flush and eof");
    drain("R5 drained all three");
    wr1(0); wr1(1); wr1(0);
    step(0, 0, 0, 1, 1, 1, "R5 flush beats eof");
    drain("R5 drained flush eof");
    for (int k = 0; k < BUFW - 1; k++) wr1(k == 7);
    step(1, 0, 0, 0, 1, 1, "R5 eof beats full");
    drain("R5 drained eof full");
    // R4 then R6
    for (int k = 0; k < BUFW; k++) wr1((k % 4) == 3);
    drain("R4 full buffer drained");
    wr1(1);
    step(0, 0, 0, 0, 1, 1, "R6 restart offset 0");
    drain("R6 drained");

    // R9 / R10: stall on full ring, drop a second close
    @(negedge clk);
    forced = IDX_W'((m_slot + 1) % DEPTH);
    pin_tail = 1;
    wr1(0); wr1(1);
    step(0, 0, 0, 0, 1, 1, "R9 stalled descriptor");
    repeat (2) settle();
    chk(overflow == 1, "R9 overflow", 128'(overflow), 1);
    chk(desc_vld == 0, "R9 no request", 128'(desc_vld), 0);
    step(1, 1, 0, 0, 1, 0, "R10 dropped");
    settle();
    chk(overflow == 1, "R10 still held", 128'(overflow), 1);
    @(negedge clk);
    pin_tail = 0;
    drain("R10 only one descriptor");
    chk(desc_vld == 0 && overflow == 0, "R10 idle after release", 128'({desc_vld, overflow}), 0);

    // R11: no pulse while not accepted
    desc_rdy = 0;
    step(0, 0, 0, 0, 1, 1, "R11 delayed accept");
    repeat (3) settle();
    chk(desc_vld == 1, "R11 request waits", 128'(desc_vld), 1);
    chk(irq == 0, "R11 no pulse before accept", 128'(irq), 0);
    @(negedge clk);
    desc_rdy = 1;
    drain("R11 drained");

    // R8: take the wrap count through all values
    for (int k = 0; k < 130; k++) begin
      step(1, 1, 0, 0, 1, 1, "R8 wrap run");
      drain("R8 drained");
    end
    chk(m_wraps >= 1, "R8 wrap count wrapped", 128'(m_wraps), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule